// File: doc/BRIEF.md
# Nested Field-Split Third-Order Error-Feedback Modulator

This block turns a wide unsigned sample word into a short signed code whose long-run average equals the input. A plain third-order error-feedback loop would need to run on the full input width. Here the word is cut into a high field, a middle field and a low field instead. The lower fields are noise-shaped by cheaper first- and second-order error-feedback stages. The short result of each lower stage is added onto the field above it, with its least significant bit aligned to that field's least significant bit. The third-order stage then only handles the high field plus a small carry term. A two-bit configuration input selects one of four paths:

- the conventional full-width loop;
- two forms in which the combined middle-and-low bits pass through a single first- or second-order stage;
- the fully nested three-stage form.

An optional one-bit pseudorandom dither can be added at the least significant bit of whichever path is active. It is either applied directly or passed through a first-difference shaping filter. Every stage advances on one shared sample strobe. The combinational path adds no pipeline skew, so the output register always holds the code for the sample presented at the strobe that loaded it. Field widths are parameters. The high and middle fields must each be at least five bits wide.

Top module: `nested_split_dsm`

## Requirements
- R1: `cfg` selects the path: 0 = full-width third-order loop; 1 = low M+L bits through a first-order stage; 2 = low M+L bits through a second-order stage; 3 = nested (low L bits first-order, then middle M bits second-order). `y` is a signed code of weight 2^S with S = W_TRUNC + W_MID + W_LO.
- R2: With all stage state cleared by reset, the first output is floor((x + t0) / 2^S) in every configuration. Here t0 is the dither term of the first sample (0 when dither is off).
- R3: With dither off and x an exact multiple of 2^S, every output equals x / 2^S in every configuration.
- R4: Over any run that starts at reset, |2^S·Σy − Σ(x + t)| ≤ 3·2^S in every configuration, where t is the dither term of each sample.
- R5: The first-order nested stage output stays in [-1, 2] and the second-order nested stage output stays in [-2, 3]. Any stage of order k differs from floor(u/2^Q) by at most 0/1, −1/2 or −3/4 for k = 1, 2, 3.
- R6: With unshaped dither, the added term is bit 15 of a 16-bit shift register. The register shifts left, feeding the XOR of bits 15, 13, 12 and 10 into bit 0. It starts at SEED (default 0xACE1) and advances once per strobe whether dither is on or off.
- R7: With shaped dither, the added term is d[n] − d[n−1], with d[−1] = 0. With dither off, the added term is 0. The term is always added at the least significant field of the active path.
- R8: While `en` is low, `y` and all stage and dither state hold, and later samples are unaffected by the pause.
- R9: During reset `y` is 0, all error history is 0 and the shift register holds SEED.
- R10: Full-scale input (all ones), including a +1 dither term, does not wrap any internal sum, so R4 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Sample strobe; all stages advance when high |
| cfg | input | 2 | Path selection (R1) |
| dith_on | input | 1 | Adds the pseudorandom dither term |
| dith_shaped | input | 1 | 1 = first-difference dither, 0 = direct bit |
| x | input | W_HI+W_MID+W_LO | Unsigned input sample |
| y | output | W_HI−W_TRUNC+6 | Signed modulated output code, registered |

## Verification
Within a single sample, the dither term and a full-field carry can coincide. The low field is all ones, so adding +1 from the dither forces every lower stage to carry into the field above in the same cycle that the final stage quantizes. This is provoked by inputs of the form k·2^S − 1 and by full-scale input with dither enabled, in both the nested and the full-width paths. It is judged in two ways. The first output must equal the rounded-down sum including the carry. The long-run sum must then stay within the fixed bound of the modelled input-plus-dither total, while range assertions watch each lower stage's excursion.

// File: rtl/dsm_split_pkg.sv
package dsm_split_pkg;

    typedef enum logic [1:0] {
        CFG_FULL     = 2'd0,
        CFG_SPLIT_O1 = 2'd1,
        CFG_SPLIT_O2 = 2'd2,
        CFG_NESTED   = 2'd3
    } split_cfg_e;

    // Width of every lower-stage output code (input field + 2 guard bits + 4 excursion bits - Q)
    localparam int LOW_YW = 6;

    // Pseudorandom source: 16-bit shift register, feedback from bits 15,13,12,10
    localparam int          PRBS_W    = 16;
    localparam logic [15:0] PRBS_TAPS = 16'hB400;

endpackage

// File: rtl/dsm_efm_stage.sv
module dsm_efm_stage #(
    parameter  int ORDER = 1,
    parameter  int Q     = 4,
    parameter  int W_IN  = 8,
    localparam int W_V   = W_IN + 4,
    localparam int W_Y   = W_V - Q
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic signed [W_IN-1:0] u,
    output logic signed [W_Y-1:0]  y
);

    typedef struct packed {
        logic [ORDER-1:0][Q-1:0] hist;
    } stage_st_t;

    stage_st_t st_d, st_q;

    logic signed [W_V-1:0] u_ext;
    logic signed [W_V-1:0] fb;
    logic signed [W_V-1:0] v;
    logic signed [W_V-1:0] ez [ORDER];

    assign u_ext = {{4{u[W_IN-1]}}, u};

    for (genvar k = 0; k < ORDER; k++) begin : g_ext
        assign ez[k] = {{(W_V-Q){1'b0}}, st_q.hist[k]};
    end

    // Feedback filter chosen so that the noise transfer is (1 - z^-1)^ORDER
    if (ORDER == 1) begin : g_o1
        assign fb = ez[0];
    end else if (ORDER == 2) begin : g_o2
        assign fb = ez[0] + ez[0] - ez[1];
    end else begin : g_o3
        assign fb = ez[0] + ez[0] + ez[0] - ez[1] - ez[1] - ez[1] + ez[2];
    end

    always_comb begin
        st_d = st_q;
        v    = u_ext + fb;
        y    = v[W_V-1:Q];
        if (en) begin
            st_d.hist[0] = v[Q-1:0];
            for (int k = 1; k < ORDER; k++) begin
                st_d.hist[k] = st_q.hist[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Excursion of the quantized code above floor(u / 2^Q)
    localparam int EXC_LO = (ORDER == 1) ? 0 : (ORDER == 2) ? 1 : 3;
    localparam int EXC_HI = (ORDER == 1) ? 1 : (ORDER == 2) ? 2 : 4;

    logic signed [W_V-1:0] y_ext;
    logic signed [W_V-1:0] drift;
    assign y_ext = {{Q{y[W_Y-1]}}, y};
    assign drift = y_ext - (u_ext >>> Q);

    p_excursion_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drift >= -EXC_LO) && (drift <= EXC_HI));

    p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.hist));

endmodule

// File: rtl/dsm_prbs_dither.sv
module dsm_prbs_dither
    import dsm_split_pkg::*;
#(
    parameter logic [PRBS_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dith_on,
    input  logic              dith_shaped,
    output logic signed [1:0] term
);

    typedef struct packed {
        logic [PRBS_W-1:0] sr;
        logic              prev;
    } prbs_st_t;

    prbs_st_t st_d, st_q;
    logic     d_now;

    always_comb begin
        st_d  = st_q;
        d_now = st_q.sr[PRBS_W-1];
        if (en) begin
            st_d.sr   = {st_q.sr[PRBS_W-2:0], ^(st_q.sr & PRBS_TAPS)};
            st_d.prev = d_now;
        end
        if (!dith_on)         term = 2'sd0;
        else if (dith_shaped) term = {1'b0, d_now} - {1'b0, st_q.prev};
        else                  term = {1'b0, d_now};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: SEED, prev: 1'b0};
        else        st_q <= st_d;
    end

    p_prbs_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr != '0);

    p_prbs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.sr));

    p_dither_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dith_on |-> term == 2'sd0);

endmodule

// File: rtl/nested_split_dsm.sv
module nested_split_dsm
    import dsm_split_pkg::*;
#(
    parameter  int                W_HI    = 7,
    parameter  int                W_MID   = 7,
    parameter  int                W_LO    = 6,
    parameter  int                W_TRUNC = 3,
    parameter  logic [PRBS_W-1:0] SEED    = 16'hACE1,
    localparam int                W_X     = W_HI + W_MID + W_LO,
    localparam int                W_OUT   = W_HI - W_TRUNC + 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [1:0]              cfg,
    input  logic                    dith_on,
    input  logic                    dith_shaped,
    input  logic [W_X-1:0]          x,
    output logic signed [W_OUT-1:0] y
);

    localparam int W_LL  = W_MID + W_LO;
    localparam int SHIFT = W_TRUNC + W_LL;

    split_cfg_e cfg_e;
    assign cfg_e = split_cfg_e'(cfg);

    // ---------------- dither source ----------------
    logic signed [1:0] dt;

    dsm_prbs_dither #(.SEED(SEED)) u_dither (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .dith_on    (dith_on),
        .dith_shaped(dith_shaped),
        .term       (dt)
    );

    // ---------------- nested lower chain ----------------
    logic signed [W_LO+1:0]  u_lo;
    logic signed [LOW_YW-1:0] y1n;
    logic signed [W_MID+1:0] u_mid;
    logic signed [LOW_YW-1:0] y2n;

    assign u_lo = $signed({2'b00, x[W_LO-1:0]}) + $signed({{W_LO{dt[1]}}, dt});

    dsm_efm_stage #(.ORDER(1), .Q(W_LO), .W_IN(W_LO+2)) u_n1 (
        .clk(clk), .rst_n(rst_n), .en(en), .u(u_lo), .y(y1n)
    );

    assign u_mid = $signed({2'b00, x[W_LL-1:W_LO]})
                 + $signed({{(W_MID-4){y1n[LOW_YW-1]}}, y1n});

    dsm_efm_stage #(.ORDER(2), .Q(W_MID), .W_IN(W_MID+2)) u_n2 (
        .clk(clk), .rst_n(rst_n), .en(en), .u(u_mid), .y(y2n)
    );

    // ---------------- two-field lower stages ----------------
    logic signed [W_LL+1:0]   u_wide;
    logic signed [LOW_YW-1:0] y1w;
    logic signed [LOW_YW-1:0] y2w;

    assign u_wide = $signed({2'b00, x[W_LL-1:0]}) + $signed({{W_LL{dt[1]}}, dt});

    dsm_efm_stage #(.ORDER(1), .Q(W_LL), .W_IN(W_LL+2)) u_w1 (
        .clk(clk), .rst_n(rst_n), .en(en), .u(u_wide), .y(y1w)
    );

    dsm_efm_stage #(.ORDER(2), .Q(W_LL), .W_IN(W_LL+2)) u_w2 (
        .clk(clk), .rst_n(rst_n), .en(en), .u(u_wide), .y(y2w)
    );

    // ---------------- recombination and final third-order stage ----------------
    logic signed [LOW_YW-1:0] y_low;
    logic signed [W_HI+1:0]   u_top;
    logic signed [W_OUT-1:0]  y_split;

    always_comb begin
        case (cfg_e)
            CFG_SPLIT_O1: y_low = y1w;
            CFG_SPLIT_O2: y_low = y2w;
            CFG_NESTED:   y_low = y2n;
            default:      y_low = '0;
        endcase
    end

    assign u_top = $signed({2'b00, x[W_X-1:W_LL]})
                 + $signed({{(W_HI-4){y_low[LOW_YW-1]}}, y_low});

    dsm_efm_stage #(.ORDER(3), .Q(W_TRUNC), .W_IN(W_HI+2)) u_top3 (
        .clk(clk), .rst_n(rst_n), .en(en), .u(u_top), .y(y_split)
    );

    // ---------------- conventional full-width path ----------------
    logic signed [W_X+1:0]   u_full;
    logic signed [W_OUT-1:0] y_full;

    assign u_full = $signed({2'b00, x}) + $signed({{W_X{dt[1]}}, dt});

    dsm_efm_stage #(.ORDER(3), .Q(SHIFT), .W_IN(W_X+2)) u_full3 (
        .clk(clk), .rst_n(rst_n), .en(en), .u(u_full), .y(y_full)
    );

    // ---------------- output register ----------------
    typedef struct packed {
        logic signed [W_OUT-1:0] y;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (en) out_d.y = (cfg_e == CFG_FULL) ? y_full : y_split;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign y = out_q.y;

    p_nest_o1_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (y1n >= -1) && (y1n <= 2));

    p_nest_o2_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (y2n >= -2) && (y2n <= 3));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(y));

endmodule

// File: tb/tb_nested_split_dsm.sv
module tb_nested_split_dsm;

    localparam int CLK_PERIOD = 10;
    localparam int H   = 5;
    localparam int M   = 5;
    localparam int L   = 3;
    localparam int QT  = 1;
    localparam int WX  = H + M + L;       // 13
    localparam int WO  = H - QT + 6;      // 10
    localparam int S   = QT + M + L;      // 9
    localparam int N_PLAIN = 2048;
    localparam int N_DITH  = 8192;
    localparam int N_VEC   = 26;

    // vector: {cfg[2], dith_on, dith_shaped, x[13], expected first output[10]}
    localparam logic [26:0] VEC [N_VEC] = '{
        {2'd0, 1'b0, 1'b0, 13'd0,    10'd0},
        {2'd0, 1'b0, 1'b0, 13'd2560, 10'd5},
        {2'd0, 1'b0, 1'b0, 13'd1535, 10'd2},
        {2'd0, 1'b0, 1'b0, 13'd8191, 10'd15},
        {2'd0, 1'b0, 1'b0, 13'd2000, 10'd3},
        {2'd1, 1'b0, 1'b0, 13'd0,    10'd0},
        {2'd1, 1'b0, 1'b0, 13'd2560, 10'd5},
        {2'd1, 1'b0, 1'b0, 13'd1535, 10'd2},
        {2'd1, 1'b0, 1'b0, 13'd8191, 10'd15},
        {2'd1, 1'b0, 1'b0, 13'd2000, 10'd3},
        {2'd2, 1'b0, 1'b0, 13'd0,    10'd0},
        {2'd2, 1'b0, 1'b0, 13'd2560, 10'd5},
        {2'd2, 1'b0, 1'b0, 13'd1535, 10'd2},
        {2'd2, 1'b0, 1'b0, 13'd8191, 10'd15},
        {2'd2, 1'b0, 1'b0, 13'd2000, 10'd3},
        {2'd3, 1'b0, 1'b0, 13'd0,    10'd0},
        {2'd3, 1'b0, 1'b0, 13'd2560, 10'd5},
        {2'd3, 1'b0, 1'b0, 13'd1535, 10'd2},
        {2'd3, 1'b0, 1'b0, 13'd8191, 10'd15},
        {2'd3, 1'b0, 1'b0, 13'd2000, 10'd3},
        {2'd0, 1'b1, 1'b0, 13'd1535, 10'd3},
        {2'd3, 1'b1, 1'b0, 13'd1535, 10'd3},
        {2'd2, 1'b1, 1'b1, 13'd2000, 10'd3},
        {2'd1, 1'b1, 1'b1, 13'd8191, 10'd16},
        {2'd3, 1'b1, 1'b1, 13'd0,    10'd0},
        {2'd0, 1'b1, 1'b0, 13'd8191, 10'd16}
    };

    logic                 clk;
    logic                 rst_n;
    logic                 en;
    logic [1:0]           cfg;
    logic                 dith_on;
    logic                 dith_shaped;
    logic [WX-1:0]        x;
    logic signed [WO-1:0] y;

    int n_checks = 0;
    int n_fail   = 0;

    nested_split_dsm #(.W_HI(H), .W_MID(M), .W_LO(L), .W_TRUNC(QT)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg), .dith_on(dith_on),
        .dith_shaped(dith_shaped), .x(x), .y(y)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] c, input logic don, input logic dsh, input logic [WX-1:0] xv);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0;
        cfg = c; dith_on = don; dith_shaped = dsh; x = xv;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(y == 0, "R9 reset output", y, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; cfg = 2'd0; dith_on = 1'b0; dith_shaped = 1'b0; x = '0;

        // ---- table of configurations, inputs and expected first codes ----
        for (int i = 0; i < N_VEC; i++) begin
            logic [1:0]    vc;
            logic          vdon, vdsh;
            logic [WX-1:0] vx;
            logic [9:0]    vexp;
            logic [15:0]   lf;
            logic          dprev;
            longint        sum_y, sum_u, diff;
            int            nsamp;
            bit            const_ok;
            {vc, vdon, vdsh, vx, vexp} = VEC[i];
            nsamp = vdon ? N_DITH : N_PLAIN;
            do_reset(vc, vdon, vdsh, vx);
            en = 1'b1;
            lf = 16'hACE1; dprev = 1'b0;
            sum_y = 0; sum_u = 0; const_ok = 1'b1;
            for (int n = 0; n < nsamp; n++) begin
                int t;
                logic dn;
                dn = lf[15];
                if (!vdon)     t = 0;
                else if (vdsh) t = int'(dn) - int'(dprev);
                else           t = int'(dn);
                dprev = dn;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                sum_u += longint'(vx) + t;
                @(negedge clk);
                sum_y += longint'(y);
                if (n == 0)
                    check(y == $signed(vexp),
                          $sformatf("R2 %s first sample cfg=%0d", vdon ? "R6" : "", vc),
                          y, $signed(vexp));
                if (!vdon && (vx % (1 << S) == 0) && (y != longint'(vx >> S)))
                    const_ok = 1'b0;
            end
            if (!vdon && (vx % (1 << S) == 0))
                check(const_ok, $sformatf("R3 exact input cfg=%0d", vc), y, vx >> S);
            diff = sum_y * (64'sd1 <<< S) - sum_u;
            check((diff <= 3 * (1 << S)) && (diff >= -3 * (1 << S)),
                  $sformatf("R1 R4 %s%s%s mean cfg=%0d x=%0d",
                            (vx == 8191) ? "R10 " : "",
                            (vdon && !vdsh) ? "R6 " : "",
                            (vdon && vdsh) ? "R7 " : "", vc, vx),
                  sum_y * (64'sd1 <<< S), sum_u);
        end

        // ---- directed: sample strobe pauses (R8) ----
        begin
            longint sum_y, sum_u, diff;
            logic signed [WO-1:0] last;
            bit hold_ok;
            do_reset(2'd3, 1'b0, 1'b0, 13'd1535);
            sum_y = 0; sum_u = 0; hold_ok = 1'b1; last = '0;
            for (int k = 0; k < 600; k++) begin
                en = 1'b1;
                @(negedge clk);
                sum_y += longint'(y);
                sum_u += 1535;
                last = y;
                if (k % 3 == 2) begin
                    en = 1'b0;
                    for (int g = 0; g < 2; g++) begin
                        @(negedge clk);
                        if (y != last) hold_ok = 1'b0;
                    end
                end
            end
            check(hold_ok, "R8 output held while strobe low", y, last);
            diff = sum_y * (64'sd1 <<< S) - sum_u;
            check((diff <= 3 * (1 << S)) && (diff >= -3 * (1 << S)),
                  "R8 R4 mean unaffected by pauses", sum_y * (64'sd1 <<< S), sum_u);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule